// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the cache-line misses that a non-blocking data cache has in flight behind an in-order pipeline. When a load misses, the pipeline offers it on the miss port. If no entry exists for its line, the load takes a free entry and a memory request leaves on the same cycle. If an entry for that line already exists, the load joins it and no new request is sent. Each entry records the line address, and for every word of the line it records which destination register, if any, waits for that word. The load's destination register is marked empty in a scoreboard. The pipeline then releases the load and continues. The decode stage asks the scoreboard about its two source registers and is held while either one is empty.

Every memory request carries the index of its entry as a tag, so refills can come back in any order. When a refill is accepted, a small state machine (states `DR_IDLE` and `DR_WRITE`) writes the waiting words back to their registers, one word per cycle in ascending word order, and marks each register full. After the last word is written, the entry is freed. The transitions are:
- `DR_IDLE`→`DR_WRITE` on an accepted refill.
- `DR_WRITE`→`DR_WRITE` while more than one waiting word remains.
- `DR_WRITE`→`DR_IDLE` on the last word.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is in use and every register is full, so `miss_ready` and `fill_ready` are high while `wb_valid`, `mem_req_valid` and `dec_stall` are low.
- R2: A miss accepted for a line without an entry takes the lowest-numbered free entry. In the same cycle it raises `mem_req_valid`, with `mem_req_line` set to the line and `mem_req_tag` set to that entry's index.
- R3: A miss accepted for a line that has an entry joins that entry and raises no memory request.
- R4: A miss whose word slot is already claimed in its line's entry sees `miss_ready` low.
- R5: When every entry is in use, a miss to a line without an entry sees `miss_ready` low. A miss that can join an existing entry is still accepted.
- R6: A miss whose destination register is already empty sees `miss_ready` low.
- R7: An accepted miss marks its destination register empty from the next cycle. `dec_stall` is high exactly when `dec_rs1` or `dec_rs2` names an empty register.
- R8: From the cycle after a refill is accepted, the block writes back one waiting word per cycle in ascending word order. `wb_rd` is that word's register and `wb_data` is the word. Word w is `fill_data[w*DATA_W +: DATA_W]`. Each register reads full from the cycle after its write-back.
- R9: `fill_ready` is low from the cycle after a refill is accepted through the cycle of its last write-back, and high again on the next cycle. That entry is free from that same cycle.
- R10: A refill selects its entry by `fill_tag`, so refills may arrive in a different order than their requests.
- R11: A miss to the line whose entry is being written back sees `miss_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load miss is offered |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_word | input | WORD_W | Word within the line |
| miss_rd | input | REG_W | Destination register of the load |
| miss_ready | output | 1 | The offered miss is accepted this cycle |
| mem_req_valid | output | 1 | A new line request goes to memory |
| mem_req_line | output | LINE_AW | Line address of the request |
| mem_req_tag | output | TAG_W | Entry index carried by the request |
| fill_valid | input | 1 | A refill line is offered |
| fill_tag | input | TAG_W | Entry index of the refill |
| fill_data | input | WORDS*DATA_W | Whole refilled line, word 0 in the low bits |
| fill_ready | output | 1 | The offered refill is accepted this cycle |
| wb_valid | output | 1 | A register write-back is made this cycle |
| wb_rd | output | REG_W | Register being written |
| wb_data | output | DATA_W | Word being written |
| dec_rs1 | input | REG_W | First decode source register |
| dec_rs2 | input | REG_W | Second decode source register |
| dec_stall | output | 1 | Decode must hold |

## Verification
A per-word register map that is lost or stale appears at the write-back port within a few cycles of the refill, either as a wrong `wb_rd` or as a missing or extra write-back. A full/empty bit left set appears as `dec_stall` stuck high. A bit that is never set lets decode run ahead, which shows as `dec_stall` low one cycle after the miss is accepted. An entry that is not freed, or that is matched wrongly, appears as a wrong `miss_ready`, a missing `mem_req_valid` or a wrong `mem_req_tag` on the next miss to that line. For these reasons the bench compares every output on every cycle against a behavioural model, so any such fault shows up on the first cycle it reaches a port.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    typedef enum logic [0:0] {
        DR_IDLE  = 1'b0,
        DR_WRITE = 1'b1
    } drain_state_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry #(
    parameter int LINE_AW = 26,
    parameter int WORDS   = 4,
    parameter int REG_W   = 5,
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            alloc_i,
    input  logic                            merge_i,
    input  logic [LINE_AW-1:0]              line_i,
    input  logic [WORD_W-1:0]               word_i,
    input  logic [REG_W-1:0]                rd_i,
    input  logic                            clr_i,
    input  logic [WORD_W-1:0]               clr_word_i,
    input  logic                            free_i,
    output logic                            valid_o,
    output logic [LINE_AW-1:0]              line_o,
    output logic [WORDS-1:0]                pend_o,
    output logic [WORDS-1:0][REG_W-1:0]     rd_o
);
    logic                        valid_q;
    logic [LINE_AW-1:0]          line_q;
    logic [WORDS-1:0]            pend_q;
    logic [WORDS-1:0][REG_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            line_q  <= '0;
            pend_q  <= '0;
            rd_q    <= '0;
        end else if (free_i) begin
            valid_q <= 1'b0;
            pend_q  <= '0;
        end else if (alloc_i) begin
            valid_q      <= 1'b1;
            line_q       <= line_i;
            pend_q       <= WORDS'(1) << word_i;
            rd_q[word_i] <= rd_i;
        end else begin
            if (merge_i) begin
                pend_q[word_i] <= 1'b1;
                rd_q[word_i]   <= rd_i;
            end
            if (clr_i) begin
                pend_q[clr_word_i] <= 1'b0;
            end
        end
    end

    assign valid_o = valid_q;
    assign line_o  = line_q;
    assign pend_o  = pend_q;
    assign rd_o    = rd_q;
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
    parameter int NREG   = 32,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [REG_W-1:0] set_idx_i,
    input  logic             clr_i,
    input  logic [REG_W-1:0] clr_idx_i,
    input  logic [REG_W-1:0] rs1_i,
    input  logic [REG_W-1:0] rs2_i,
    output logic [NREG-1:0]  empty_o,
    output logic             stall_o
);
    logic [NREG-1:0] empty_q;
    logic [NREG-1:0] set_mask;
    logic [NREG-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_i) set_mask[set_idx_i] = 1'b1;
        if (clr_i) clr_mask[clr_idx_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) empty_q <= '0;
        else        empty_q <= (empty_q | set_mask) & ~clr_mask;
    end

    assign empty_o = empty_q;
    assign stall_o = empty_q[rs1_i] | empty_q[rs2_i];
endmodule

// File: rtl/mshr_drain.sv
module mshr_drain
    import mshr_pkg::*;
#(
    parameter int NENT    = 4,
    parameter int WORDS   = 4,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 32,
    localparam int TAG_W  = $clog2(NENT),
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                fill_valid,
    input  logic [TAG_W-1:0]                    fill_tag,
    input  logic [WORDS*DATA_W-1:0]             fill_data,
    output logic                                fill_ready,
    input  logic [NENT-1:0][WORDS-1:0]          ent_pend,
    input  logic [NENT-1:0][WORDS-1:0][REG_W-1:0] ent_rd,
    output logic                                busy_o,
    output logic [TAG_W-1:0]                    tag_o,
    output logic                                clr_o,
    output logic [WORD_W-1:0]                   clr_word_o,
    output logic                                free_o,
    output logic                                wb_valid,
    output logic [REG_W-1:0]                    wb_rd,
    output logic [DATA_W-1:0]                   wb_data
);
    drain_state_e                 state_q, state_d;
    logic [TAG_W-1:0]             tag_q;
    logic [WORDS-1:0][DATA_W-1:0] data_q;
    logic [WORDS-1:0]             cur_pend;
    logic [WORD_W-1:0]            pick;
    logic                         last_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
            tag_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == DR_IDLE && fill_valid) begin
                tag_q  <= fill_tag;
                data_q <= fill_data;
            end
        end
    end

    always_comb begin
        cur_pend = ent_pend[tag_q];
        pick     = '0;
        for (int w = WORDS - 1; w >= 0; w--) begin
            if (cur_pend[w]) pick = WORD_W'(w);
        end
        last_word = ($countones(cur_pend) <= 1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE:  if (fill_valid) state_d = DR_WRITE;
            DR_WRITE: if (last_word)  state_d = DR_IDLE;
            default:  state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        fill_ready = 1'b0;
        clr_o      = 1'b0;
        free_o     = 1'b0;
        wb_valid   = 1'b0;
        wb_rd      = '0;
        wb_data    = '0;
        unique case (state_q)
            DR_IDLE: fill_ready = 1'b1;
            DR_WRITE: begin
                free_o = last_word;
                if (|cur_pend) begin
                    wb_valid = 1'b1;
                    clr_o    = 1'b1;
                    wb_rd    = ent_rd[tag_q][pick];
                    wb_data  = data_q[pick];
                end
            end
            default: fill_ready = 1'b0;
        endcase
    end

    assign busy_o     = (state_q == DR_WRITE);
    assign tag_o      = tag_q;
    assign clr_word_o = pick;
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
    parameter int LINE_AW = 26,
    parameter int WORDS   = 4,
    parameter int NREG    = 32,
    parameter int NENT    = 4,
    parameter int DATA_W  = 32,
    localparam int WORD_W = $clog2(WORDS),
    localparam int REG_W  = $clog2(NREG),
    localparam int TAG_W  = $clog2(NENT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    input  logic [LINE_AW-1:0]      miss_line,
    input  logic [WORD_W-1:0]       miss_word,
    input  logic [REG_W-1:0]        miss_rd,
    output logic                    miss_ready,
    output logic                    mem_req_valid,
    output logic [LINE_AW-1:0]      mem_req_line,
    output logic [TAG_W-1:0]        mem_req_tag,
    input  logic                    fill_valid,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [WORDS*DATA_W-1:0] fill_data,
    output logic                    fill_ready,
    output logic                    wb_valid,
    output logic [REG_W-1:0]        wb_rd,
    output logic [DATA_W-1:0]       wb_data,
    input  logic [REG_W-1:0]        dec_rs1,
    input  logic [REG_W-1:0]        dec_rs2,
    output logic                    dec_stall
);
    logic [NENT-1:0]                        ent_valid;
    logic [NENT-1:0][LINE_AW-1:0]           ent_line;
    logic [NENT-1:0][WORDS-1:0]             ent_pend;
    logic [NENT-1:0][WORDS-1:0][REG_W-1:0]  ent_rd;
    logic [NREG-1:0]                        sb_empty;

    logic             any_hit, any_free;
    logic [TAG_W-1:0] hit_idx, free_idx;
    logic             slot_taken, drain_hit, accept, do_alloc, do_merge;

    logic              drain_busy, drain_clr, drain_free;
    logic [TAG_W-1:0]  drain_tag;
    logic [WORD_W-1:0] drain_word;

    always_comb begin
        any_hit  = 1'b0;
        any_free = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (ent_valid[i] && ent_line[i] == miss_line) begin
                any_hit = 1'b1;
                hit_idx = TAG_W'(i);
            end
            if (!ent_valid[i]) begin
                any_free = 1'b1;
                free_idx = TAG_W'(i);
            end
        end
    end

    assign slot_taken = ent_pend[hit_idx][miss_word];
    assign drain_hit  = drain_busy && (drain_tag == hit_idx);

    always_comb begin
        if (sb_empty[miss_rd])  miss_ready = 1'b0;
        else if (any_hit)       miss_ready = !slot_taken && !drain_hit;
        else                    miss_ready = any_free;
    end

    assign accept        = miss_valid && miss_ready;
    assign do_alloc      = accept && !any_hit;
    assign do_merge      = accept && any_hit;
    assign mem_req_valid = do_alloc;
    assign mem_req_line  = miss_line;
    assign mem_req_tag   = free_idx;

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        mshr_entry #(
            .LINE_AW (LINE_AW),
            .WORDS   (WORDS),
            .REG_W   (REG_W)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (do_alloc && free_idx == TAG_W'(g)),
            .merge_i    (do_merge && hit_idx == TAG_W'(g)),
            .line_i     (miss_line),
            .word_i     (miss_word),
            .rd_i       (miss_rd),
            .clr_i      (drain_clr && drain_tag == TAG_W'(g)),
            .clr_word_i (drain_word),
            .free_i     (drain_free && drain_tag == TAG_W'(g)),
            .valid_o    (ent_valid[g]),
            .line_o     (ent_line[g]),
            .pend_o     (ent_pend[g]),
            .rd_o       (ent_rd[g])
        );
    end

    mshr_drain #(
        .NENT   (NENT),
        .WORDS  (WORDS),
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
    ) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_tag   (fill_tag),
        .fill_data  (fill_data),
        .fill_ready (fill_ready),
        .ent_pend   (ent_pend),
        .ent_rd     (ent_rd),
        .busy_o     (drain_busy),
        .tag_o      (drain_tag),
        .clr_o      (drain_clr),
        .clr_word_o (drain_word),
        .free_o     (drain_free),
        .wb_valid   (wb_valid),
        .wb_rd      (wb_rd),
        .wb_data    (wb_data)
    );

    mshr_scoreboard #(
        .NREG (NREG)
    ) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (accept),
        .set_idx_i (miss_rd),
        .clr_i     (wb_valid),
        .clr_idx_i (wb_rd),
        .rs1_i     (dec_rs1),
        .rs2_i     (dec_rs2),
        .empty_o   (sb_empty),
        .stall_o   (dec_stall)
    );
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
    parameter int NREG   = 32,
    localparam int REG_W = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_valid,
    input logic             miss_ready,
    input logic [REG_W-1:0] miss_rd,
    input logic             mem_req_valid,
    input logic             fill_ready,
    input logic             wb_valid,
    input logic [REG_W-1:0] wb_rd,
    input logic [NREG-1:0]  reg_empty
);
    // R2
    req_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (miss_valid && miss_ready));

    // R6
    busy_dest_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && reg_empty[miss_rd]) |-> !miss_ready);

    // R7
    accept_marks_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> reg_empty[$past(miss_rd)]);

    // R8
    wb_targets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> reg_empty[wb_rd]);

    // R8
    wb_releases_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !reg_empty[$past(wb_rd)]);

    // R9
    no_fill_while_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !fill_ready);

    // R9
    drain_end_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_valid) |-> fill_ready);
endmodule

bind mshr_file mshr_file_chk #(.NREG(NREG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .miss_rd       (miss_rd),
    .mem_req_valid (mem_req_valid),
    .fill_ready    (fill_ready),
    .wb_valid      (wb_valid),
    .wb_rd         (wb_rd),
    .reg_empty     (sb_empty)
);

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_AW = 26;
    localparam int WORDS   = 4;
    localparam int NREG    = 32;
    localparam int NENT    = 4;
    localparam int DATA_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic                    miss_valid = 1'b0;
    logic [LINE_AW-1:0]      miss_line = '0;
    logic [1:0]              miss_word = '0;
    logic [4:0]              miss_rd = '0;
    logic                    miss_ready;
    logic                    mem_req_valid;
    logic [LINE_AW-1:0]      mem_req_line;
    logic [1:0]              mem_req_tag;
    logic                    fill_valid = 1'b0;
    logic [1:0]              fill_tag = '0;
    logic [WORDS*DATA_W-1:0] fill_data = '0;
    logic                    fill_ready;
    logic                    wb_valid;
    logic [4:0]              wb_rd;
    logic [DATA_W-1:0]       wb_data;
    logic [4:0]              dec_rs1 = '0;
    logic [4:0]              dec_rs2 = '0;
    logic                    dec_stall;

    mshr_file u_dut (.*);

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    bit mv[NENT];
    int mline[NENT];
    int mrd[NENT][WORDS];
    bit mempty[NREG];
    bit busy;
    int mtag;
    int mdata[WORDS];
    int fseed = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit v, input int line, input int w, input int rd,
                       input bit fv, input int ftag, input int rs1, input int rs2);
        int hit, fr, wbw;
        bit rdy, left;
        @(negedge clk);
        miss_valid = v; miss_line = LINE_AW'(line); miss_word = 2'(w); miss_rd = 5'(rd);
        fill_valid = fv; fill_tag = 2'(ftag);
        for (int k = 0; k < WORDS; k++) fill_data[k*DATA_W +: DATA_W] = 32'(fseed * 16 + k);
        dec_rs1 = 5'(rs1); dec_rs2 = 5'(rs2);
        #1;
        hit = -1; fr = -1;
        for (int e = NENT - 1; e >= 0; e--) begin
            if (mv[e] && mline[e] == line) hit = e;
            if (!mv[e]) fr = e;
        end
        if (mempty[rd])    rdy = 0;
        else if (hit >= 0) rdy = !(busy && mtag == hit) && mrd[hit][w] < 0;
        else               rdy = (fr >= 0);
        wbw = -1;
        if (busy) for (int k = WORDS - 1; k >= 0; k--) if (mrd[mtag][k] >= 0) wbw = k;

        chk(miss_ready == rdy, "R3 miss_ready", int'(miss_ready), int'(rdy));
        chk(mem_req_valid == (v && rdy && hit < 0), "R2 mem_req_valid", int'(mem_req_valid), int'(v && rdy && hit < 0));
        if (v && rdy && hit < 0) begin
            chk(int'(mem_req_tag) == fr, "R2 mem_req_tag", int'(mem_req_tag), fr);
            chk(int'(mem_req_line) == line, "R2 mem_req_line", int'(mem_req_line), line);
        end
        chk(fill_ready == !busy, "R9 fill_ready", int'(fill_ready), int'(!busy));
        chk(wb_valid == (wbw >= 0), "R8 wb_valid", int'(wb_valid), int'(wbw >= 0));
        if (wbw >= 0) begin
            chk(int'(wb_rd) == mrd[mtag][wbw], "R8 wb_rd", int'(wb_rd), mrd[mtag][wbw]);
            chk(int'(wb_data) == mdata[wbw], "R8 wb_data", int'(wb_data), mdata[wbw]);
        end
        chk(dec_stall == (mempty[rs1] || mempty[rs2]), "R7 dec_stall", int'(dec_stall), int'(mempty[rs1] || mempty[rs2]));

        // model update, as of the coming rising edge
        if (wbw >= 0) begin
            mempty[mrd[mtag][wbw]] = 0;
            mrd[mtag][wbw] = -1;
        end
        if (busy) begin
            left = 0;
            for (int k = 0; k < WORDS; k++) if (mrd[mtag][k] >= 0) left = 1;
            if (!left) begin mv[mtag] = 0; busy = 0; end
        end else if (fv) begin
            busy = 1; mtag = ftag;
            for (int k = 0; k < WORDS; k++) mdata[k] = fseed * 16 + k;
        end
        if (v && rdy) begin
            if (hit >= 0) mrd[hit][w] = rd;
            else begin
                mv[fr] = 1; mline[fr] = line;
                for (int k = 0; k < WORDS; k++) mrd[fr][k] = -1;
                mrd[fr][w] = rd;
            end
            mempty[rd] = 1;
        end
        fseed++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < NENT; e++) begin
            mv[e] = 0; mline[e] = 0;
            for (int k = 0; k < WORDS; k++) mrd[e][k] = -1;
        end
        for (int r = 0; r < NREG; r++) mempty[r] = 0;
        busy = 0; mtag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        chk(miss_ready && fill_ready && !wb_valid && !dec_stall && !mem_req_valid, "R1 reset",
            int'({miss_ready, fill_ready, wb_valid, dec_stall}), 12);

        cyc(1, 16'h10, 0, 5, 0, 0, 5, 0);                 // R2 new entry 0
        cyc(1, 16'h10, 2, 6, 0, 0, 5, 0);                 // R3 join
        chk(dec_stall == 1, "R7 stall on empty source", int'(dec_stall), 1);
        chk(mem_req_valid == 0, "R3 no request on join", int'(mem_req_valid), 0);
        cyc(1, 16'h10, 2, 7, 0, 0, 0, 0);
        chk(miss_ready == 0, "R4 claimed slot", int'(miss_ready), 0);
        cyc(1, 16'h20, 1, 5, 0, 0, 0, 0);
        chk(miss_ready == 0, "R6 busy destination", int'(miss_ready), 0);
        cyc(1, 16'h20, 1, 8, 0, 0, 0, 0);
        cyc(1, 16'h30, 0, 9, 0, 0, 0, 0);
        cyc(1, 16'h40, 3, 10, 0, 0, 0, 0);
        cyc(1, 16'h50, 0, 11, 0, 0, 0, 0);
        chk(miss_ready == 0, "R5 all entries busy", int'(miss_ready), 0);
        cyc(1, 16'h20, 3, 12, 0, 0, 0, 0);
        chk(miss_ready == 1, "R5 join while full", int'(miss_ready), 1);
        cyc(0, 0, 0, 1, 1, 2, 9, 0);                      // R10 fill entry 2 first
        cyc(0, 0, 0, 1, 0, 0, 9, 0);
        chk(wb_valid && wb_rd == 5'd9, "R10 out-of-order refill", int'(wb_rd), 9);
        cyc(0, 0, 0, 1, 0, 0, 9, 0);
        chk(dec_stall == 0, "R8 register full after write-back", int'(dec_stall), 0);
        cyc(0, 0, 0, 1, 1, 0, 0, 0);
        cyc(1, 16'h10, 1, 13, 0, 0, 0, 0);
        chk(miss_ready == 0, "R11 line in write-back", int'(miss_ready), 0);
        chk(wb_rd == 5'd5, "R8 ascending word order", int'(wb_rd), 5);
        cyc(0, 0, 0, 1, 1, 1, 0, 0);
        chk(fill_ready == 0, "R9 refill held during write-back", int'(fill_ready), 0);
        cyc(1, 16'h50, 0, 11, 0, 0, 0, 0);
        chk(mem_req_valid && mem_req_tag == 2'd0, "R2 lowest free entry", int'(mem_req_tag), 0);

        for (int n = 0; n < 600; n++) begin
            int ft;
            bit fv;
            ft = int'($urandom % NENT);
            fv = ($urandom % 4 == 0) && mv[ft];
            cyc($urandom % 2 == 0, 16 * (1 + int'($urandom % 6)), int'($urandom % WORDS),
                int'($urandom % NREG), fv, ft, int'($urandom % NREG), int'($urandom % NREG));
        end
        for (int n = 0; n < 80; n++) begin
            int ft;
            ft = n % NENT;
            cyc(0, 0, 0, 0, mv[ft], ft, n % NREG, (n + 7) % NREG);
        end
        chk(fill_ready == 1 && wb_valid == 0, "R9 all drained", int'(fill_ready), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule